// File: doc/BRIEF.md
# Two-Partition Reconfigurable Scan Wrapper

This block sits around a core whose scan cells are split into two sub-chains of equal length. A mode request picks between a narrow arrangement, where one test-access wire feeds both sub-chains in turn as a single long chain, and a wide arrangement, where two wires feed the two sub-chains side by side. Per-partition clock enables keep any sub-chain that is not shifting frozen. In narrow mode only one partition switches at a time, so shift power is about half of what full activity would draw.

An output steering stage sends each sub-chain's serial response to the correct access wire for the active arrangement. A capture pulse fires both partitions for one cycle. The scan cells themselves are a behavioural model in which a capture inverts every cell. This stands in for the core's response so that a bench can predict every bit. A change of mode only takes effect between patterns.

Top module: `scan_pair_wrapper`

## Requirements
- R1: While reset is held low and in the cycle after it is released, the active mode is narrow (`mode_wide` = 0). Both clock enables are 0, both outputs are 0, all scan cells hold 0, and the shift position counter is 0.
- R2: In narrow mode, shift cycle positions 0 to PART_LEN-1 of a pattern clock only sub-chain A from `tam_in1`. Positions PART_LEN to 2*PART_LEN-1 clock only sub-chain B, also from `tam_in1`. Exactly one enable is high per shift cycle.
- R3: In narrow mode, `tam_out1` carries the last cell of sub-chain A during positions 0 to PART_LEN-1 and the last cell of sub-chain B afterwards. `tam_out2` stays 0.
- R4: In wide mode, every shift cycle clocks both sub-chains. A takes `tam_in1` and B takes `tam_in2`. `tam_out1` shows A's last cell and `tam_out2` shows B's last cell.
- R5: A sub-chain whose enable is low keeps all its cells unchanged, so its later scan-out reproduces the earlier contents.
- R6: A cycle with `capture` high raises both enables for that cycle in either mode, inverts every cell of both sub-chains, and does not advance the shift position. Capture takes priority over `shift_en`.
- R7: A new value on `mode_req` is adopted only at an edge where the shift position is 0 and `shift_en` is low. Otherwise the old mode is held until the pattern finishes.
- R8: The shift position wraps to 0 after 2*PART_LEN shifts in narrow mode and after PART_LEN shifts in wide mode. The next shift then starts a new pattern at sub-chain A.
- R9: With `shift_en` and `capture` both low, both enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_req | input | 1 | Requested arrangement: 1 wide, 0 narrow |
| shift_en | input | 1 | Shift one bit this cycle |
| capture | input | 1 | Capture pulse into both sub-chains |
| tam_in1 | input | 1 | Access wire 1 scan input |
| tam_in2 | input | 1 | Access wire 2 scan input (wide mode only) |
| tam_out1 | output | 1 | Access wire 1 scan output |
| tam_out2 | output | 1 | Access wire 2 scan output (0 in narrow mode) |
| mode_wide | output | 1 | Arrangement currently in force |
| clk_en_a | output | 1 | Clock enable of sub-chain A |
| clk_en_b | output | 1 | Clock enable of sub-chain B |

## Verification
If the shift position counter drifts, the phase boundary moves. The next shift cycle then shows the wrong enable, and in narrow mode `tam_out1` switches source on the wrong cycle. A corrupted scan cell stays hidden until that bit reaches a chain end, at most 2*PART_LEN shifts later, and then appears as one wrong output bit. A mode register that updates mid-pattern shows up on `mode_wide` and on the enable pair in the very next cycle.

// File: rtl/scan_pair_pkg.sv
package scan_pair_pkg;
    typedef enum logic {
        MODE_NARROW = 1'b0,
        MODE_WIDE   = 1'b1
    } scan_mode_e;

    typedef enum logic {
        SEG_A = 1'b0,
        SEG_B = 1'b1
    } seg_sel_e;
endpackage

// File: rtl/scan_seg_ctrl.sv
module scan_seg_ctrl
    import scan_pair_pkg::*;
#(
    parameter int PART_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_req,
    input  logic shift_en,
    input  logic capture,
    output logic wide,
    output logic seg_b,
    output logic en_a,
    output logic en_b
);
    localparam int CW = $clog2(2 * PART_LEN);
    localparam logic [CW-1:0] LAST_NARROW = CW'(2 * PART_LEN - 1);
    localparam logic [CW-1:0] LAST_WIDE   = CW'(PART_LEN - 1);
    localparam logic [CW-1:0] HALF        = CW'(PART_LEN);

    typedef struct packed {
        logic [CW-1:0] pos;
        scan_mode_e    mode;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  do_shift;
    seg_sel_e seg;

    always_comb begin
        st_d     = st_q;
        do_shift = shift_en && !capture;
        seg      = (st_q.pos < HALF) ? SEG_A : SEG_B;
        if (do_shift) begin
            if (st_q.pos == ((st_q.mode == MODE_WIDE) ? LAST_WIDE : LAST_NARROW)) begin
                st_d.pos = '0;
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
        if ((st_q.pos == '0) && !shift_en) begin
            st_d.mode = scan_mode_e'(mode_req);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pos: '0, mode: MODE_NARROW};
        end else begin
            st_q <= st_d;
        end
    end

    assign wide  = (st_q.mode == MODE_WIDE);
    assign seg_b = (seg == SEG_B);
    assign en_a  = capture || (do_shift && (wide || seg == SEG_A));
    assign en_b  = capture || (do_shift && (wide || seg == SEG_B));

    assert_one_seg_narrow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide && shift_en && !capture) |-> $countones({en_a, en_b}) == 1);
    assert_both_seg_wide_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wide && shift_en && !capture) |-> (en_a && en_b));
    assert_capture_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> (en_a && en_b));
    assert_capture_holds_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> $stable(st_q.pos));
    assert_mode_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pos != '0) |=> $stable(st_q.mode));
    assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (do_shift && wide && st_q.pos == LAST_WIDE) |=> (st_q.pos == '0));
    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !capture) |-> (!en_a && !en_b));
endmodule

// File: rtl/scan_cell_chain.sv
module scan_cell_chain #(
    parameter int PART_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic capture,
    input  logic sin,
    output logic sout
);
    logic [PART_LEN-1:0] cells_d, cells_q;

    always_comb begin
        cells_d = cells_q;
        if (en) begin
            if (capture) begin
                cells_d = ~cells_q;
            end else begin
                cells_d = {cells_q[PART_LEN-2:0], sin};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cells_q <= '0;
        end else begin
            cells_q <= cells_d;
        end
    end

    assign sout = cells_q[PART_LEN-1];

    assert_gated_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cells_q));
    assert_capture_invert_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && capture) |=> (cells_q == ~$past(cells_q)));
endmodule

// File: rtl/scan_out_steer.sv
module scan_out_steer (
    input  logic wide,
    input  logic seg_b,
    input  logic so_a,
    input  logic so_b,
    output logic out1,
    output logic out2
);
    always_comb begin
        if (wide) begin
            out1 = so_a;
            out2 = so_b;
        end else begin
            out1 = seg_b ? so_b : so_a;
            out2 = 1'b0;
        end
    end

    always_comb begin
        assert_out2_quiet_R3: assert (wide || !out2);
    end
endmodule

// File: rtl/scan_pair_wrapper.sv
module scan_pair_wrapper #(
    parameter int PART_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_req,
    input  logic shift_en,
    input  logic capture,
    input  logic tam_in1,
    input  logic tam_in2,
    output logic tam_out1,
    output logic tam_out2,
    output logic mode_wide,
    output logic clk_en_a,
    output logic clk_en_b
);
    localparam int NSEG = 2;

    logic wide, seg_b;
    logic [NSEG-1:0] seg_en, seg_sin, seg_sout;

    scan_seg_ctrl #(.PART_LEN(PART_LEN)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_req (mode_req),
        .shift_en (shift_en),
        .capture  (capture),
        .wide     (wide),
        .seg_b    (seg_b),
        .en_a     (seg_en[0]),
        .en_b     (seg_en[1])
    );

    assign seg_sin[0] = tam_in1;
    assign seg_sin[1] = wide ? tam_in2 : tam_in1;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        scan_cell_chain #(.PART_LEN(PART_LEN)) u_chain (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (seg_en[g]),
            .capture (capture),
            .sin     (seg_sin[g]),
            .sout    (seg_sout[g])
        );
    end

    scan_out_steer u_steer (
        .wide  (wide),
        .seg_b (seg_b),
        .so_a  (seg_sout[0]),
        .so_b  (seg_sout[1]),
        .out1  (tam_out1),
        .out2  (tam_out2)
    );

    assign mode_wide = wide;
    assign clk_en_a  = seg_en[0];
    assign clk_en_b  = seg_en[1];
endmodule

// File: tb/scan_pair_wrapper_tb.sv
module scan_pair_wrapper_tb;
    localparam int L = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_req = 1'b0, shift_en = 1'b0, capture = 1'b0, tam_in1 = 1'b0, tam_in2 = 1'b0;
    logic tam_out1, tam_out2, mode_wide, clk_en_a, clk_en_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [L-1:0] ma = '0, mb = '0;
    int  mpos = 0;
    logic mmode = 1'b0;

    always #2 clk = ~clk;

    scan_pair_wrapper #(.PART_LEN(L)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .shift_en(shift_en),
        .capture(capture), .tam_in1(tam_in1), .tam_in2(tam_in2),
        .tam_out1(tam_out1), .tam_out2(tam_out2), .mode_wide(mode_wide),
        .clk_en_a(clk_en_a), .clk_en_b(clk_en_b)
    );

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s {mode,en_a,en_b,out1,out2} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check before the edge, update the model at the edge.
    task automatic step(input logic sh, input logic cap, input logic i1, input logic i2,
                        input logic rq, input string tag);
        logic ea, eb, o1, o2, in_a;
        logic [L-1:0] na, nb;
        int npos;
        logic nmode;
        @(negedge clk);
        shift_en = sh; capture = cap; tam_in1 = i1; tam_in2 = i2; mode_req = rq;
        #1;
        in_a = (mpos < L);
        ea = cap || (sh && (mmode || in_a));
        eb = cap || (sh && (mmode || !in_a));
        o1 = mmode ? ma[L-1] : (in_a ? ma[L-1] : mb[L-1]);
        o2 = mmode ? mb[L-1] : 1'b0;
        check(tag, {mode_wide, clk_en_a, clk_en_b, tam_out1, tam_out2}, {mmode, ea, eb, o1, o2});
        na = ma; nb = mb; npos = mpos; nmode = mmode;
        if (cap) begin
            na = ~ma; nb = ~mb;
        end else if (sh) begin
            if (ea) na = {ma[L-2:0], i1};
            if (eb) nb = {mb[L-2:0], mmode ? i2 : i1};
            npos = (mpos == (mmode ? L - 1 : 2 * L - 1)) ? 0 : mpos + 1;
        end
        if (mpos == 0 && !sh) nmode = rq;
        @(posedge clk);
        ma = na; mb = nb; mpos = npos; mmode = nmode;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", {mode_wide, clk_en_a, clk_en_b, tam_out1, tam_out2}, 5'b0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    endtask

    task automatic t_narrow(input logic [2*L-1:0] pat, input string tag);
        for (int i = 0; i < 2 * L; i++) step(1'b1, 1'b0, pat[i], 1'b1, 1'b0, tag);
    endtask

    task automatic t_capture;
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R6");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
        t_narrow(16'h0F0F, "R3");
    endtask

    task automatic t_idle;
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, i[0], ~i[0], 1'b0, "R9");
        t_narrow(16'h1234, "R5");
    endtask

    task automatic t_mode_hold;
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R7");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
        for (int i = 0; i < 2 * L - 3; i++) step(1'b1, 1'b0, i[1], 1'b0, 1'b1, "R7");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
    endtask

    task automatic t_wide;
        for (int i = 0; i < 3 * L; i++) step(1'b1, 1'b0, i[0] ^ i[2], i[1], 1'b1, "R4");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R6");
        for (int i = 0; i < L; i++) step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R8");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
        t_narrow(16'hA55A, "R8");
    endtask

    initial begin
        t_reset();
        t_narrow(16'hB5C3, "R2");
        t_narrow(16'h6E19, "R3");
        t_capture();
        t_idle();
        t_mode_hold();
        t_wide();
        t_narrow(16'h0000, "R8");
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule